// File: doc/BRIEF.md
# Processor Interrupt Interface with Priority Masking

This block sits between an interrupt distributor and a single processor. Each cycle the distributor offers one candidate: an interrupt ID, its priority, and a flag that says the interrupt is already active and pending again. The block decides whether the candidate is urgent enough to interrupt the processor. To do so it compares the candidate with a software-set priority mask and with the priority of the most urgent interrupt the processor is currently servicing. A lower numeric priority is more urgent, and every comparison is strict. When the candidate qualifies, the block raises a request line to the processor.

The processor uses a small register port. Reading the acknowledge register returns the ID of the qualifying candidate. That read pushes the candidate's ID and priority onto an in-service stack and notifies the distributor. Writing an ID to the end-of-service register completes the interrupt on top of the stack, pops it, and reports the completion to the distributor. Completions must arrive in the reverse order of acknowledgements. An out-of-order completion is refused and latched as an error. The running priority is the priority on top of the stack, or the idle value (all ones) when the stack is empty.

Top module: `cpu_irq_iface`

## Requirements
- R1: After reset the request line is low and no notification pulse is issued. The mask register reads 0. The status register reads running priority 0xFF, depth 0 and no error, which gives the value 0x000000FF.
- R2: The request line is registered. One cycle after a cycle in which a valid candidate is eligible, it is high. One cycle after the candidate stops being eligible, it is low. Examples of losing eligibility are the candidate being withdrawn or the mask being lowered.
- R3: A candidate whose priority equals the mask, or equals the running priority, is not eligible.
- R4: A candidate flagged as active-and-pending is never signalled and cannot be acknowledged.
- R5: The acknowledge register is at address 1. Reading it while a candidate is eligible returns that candidate's ID. On the next cycle the read produces a one-cycle ack pulse carrying the ID, makes the candidate's priority the running priority, and raises the depth by one. The request line is low on the cycle after the acknowledge.
- R6: Reading the acknowledge register with no eligible candidate returns the spurious ID 1023. It produces no ack pulse and leaves the status unchanged.
- R7: The end-of-service register is at address 2. Writing to it the ID on top of the stack pops that entry and restores the previous running priority. On the next cycle it produces a one-cycle completion pulse carrying that ID.
- R8: An end-of-service write whose ID is not on top of the stack, or that arrives while the stack is empty, leaves the stack unchanged and produces no completion pulse. It sets the error flag (status bit 31), which stays set until reset.
- R9: The stack holds 8 entries. While the stack is full, no candidate is signalled or acknowledged, however urgent it is.
- R10: The mask register is at address 0. Writing to it stores the low 8 data bits, and reading it returns them zero-extended. The status register is at address 3 and reads running priority in bits 7:0, depth in bits 11:8 and error in bit 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cand_valid | input | 1 | Distributor offers a candidate |
| cand_id | input | 10 | Candidate interrupt ID |
| cand_prio | input | 8 | Candidate priority, lower is more urgent |
| cand_act_pend | input | 1 | Candidate is already active and pending again |
| irq_req | output | 1 | Interrupt request to the processor |
| ack_valid | output | 1 | One-cycle pulse: candidate acknowledged |
| ack_id | output | 10 | ID acknowledged |
| eoi_valid | output | 1 | One-cycle pulse: interrupt completed |
| eoi_id | output | 10 | ID completed |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle of the read |

## Verification
The request decision is tried against candidates above, equal to and below the mask. It is also tried against candidates equal to and below the running priority, which tells the strict comparison apart from a non-strict one and separates the mask from the in-service term. Nested acknowledges down to a full stack show that depth is bounded and that the running priority follows the stack top. Withdrawing the candidate and lowering the mask show deassertion timing. Completions are tried in correct order, with a wrong ID and on an empty stack, which tells a real pop apart from a refused one.

// File: rtl/cpu_irq_pkg.sv
// Shared definitions for the processor interrupt interface.
package cpu_irq_pkg;
    // Register select values seen on the processor register port.
    typedef enum logic [1:0] {
        SEL_MASK = 2'd0,
        SEL_ACK  = 2'd1,
        SEL_EOI  = 2'd2,
        SEL_STAT = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/cpu_irq_stack.sv
// In-service stack: holds ID and priority of acknowledged interrupts.
// Assumes push and pop are never requested in the same cycle, and that
// the caller never pushes when full or pops when empty.
module cpu_irq_stack #(
    parameter int DEPTH  = 8,
    parameter int ID_W   = 10,
    parameter int PRIO_W = 8,
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [ID_W-1:0]   push_id,
    input  logic [PRIO_W-1:0] push_prio,
    input  logic              pop,
    output logic [ID_W-1:0]   top_id,
    output logic [PRIO_W-1:0] top_prio,
    output logic [CNT_W-1:0]  cnt,
    output logic              empty,
    output logic              full
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [ID_W-1:0]   id_mem [DEPTH];
    logic [PRIO_W-1:0] pr_mem [DEPTH];
    logic [CNT_W-1:0]  cnt_q;
    logic [IDX_W-1:0]  top_idx;

    // Write the entry just above the current top on push.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                id_mem[i] <= '0;
                pr_mem[i] <= '0;
            end
        end else if (push && !full) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (cnt_q == CNT_W'(i)) begin
                    id_mem[i] <= push_id;
                    pr_mem[i] <= push_prio;
                end
            end
        end
    end

    // Track how many entries are in service.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (push && !full) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end else if (pop && !empty) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    // Expose the top entry and the fill flags.
    always_comb begin
        top_idx  = IDX_W'(cnt_q - CNT_W'(1));
        top_id   = id_mem[top_idx];
        top_prio = pr_mem[top_idx];
        empty    = (cnt_q == '0);
        full     = (cnt_q == CNT_W'(DEPTH));
        cnt      = cnt_q;
    end
endmodule

// File: rtl/cpu_irq_gate.sv
// Eligibility test: a candidate qualifies only if it is strictly more
// urgent (numerically lower) than both the mask and the running priority,
// is not active-and-pending, and the in-service stack has room.
module cpu_irq_gate #(
    parameter int PRIO_W = 8
) (
    input  logic              cand_valid,
    input  logic [PRIO_W-1:0] cand_prio,
    input  logic              cand_act_pend,
    input  logic [PRIO_W-1:0] mask,
    input  logic [PRIO_W-1:0] running,
    input  logic              full,
    output logic              eligible
);
    // Combine the threshold terms into one decision.
    always_comb begin
        eligible = cand_valid && !cand_act_pend && !full
                   && (cand_prio < mask) && (cand_prio < running);
    end
endmodule

// File: rtl/cpu_irq_regs.sv
// Register port decode: produces read data and the side-effect strobes.
// Assumes a read and a write in the same cycle carry no read side effect.
module cpu_irq_regs
    import cpu_irq_pkg::*;
#(
    parameter int ID_W   = 10,
    parameter int PRIO_W = 8,
    parameter int CNT_W  = 4,
    parameter int DATA_W = 32
) (
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              eligible,
    input  logic [ID_W-1:0]   cand_id,
    input  logic [ID_W-1:0]   top_id,
    input  logic              empty,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [PRIO_W-1:0] running,
    input  logic [PRIO_W-1:0] mask,
    input  logic              err,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              ack_fire,
    output logic              eoi_hit,
    output logic              eoi_miss,
    output logic              mask_we
);
    localparam logic [ID_W-1:0] SPUR_ID = '1;

    reg_sel_e          sel;
    logic              eoi_wr;
    logic [DATA_W-1:0] stat_word;

    // Decode strobes that change state.
    always_comb begin
        sel      = reg_sel_e'(reg_addr);
        ack_fire = reg_rd && !reg_wr && (sel == SEL_ACK) && eligible;
        eoi_wr   = reg_wr && (sel == SEL_EOI);
        eoi_hit  = eoi_wr && !empty && (reg_wdata[ID_W-1:0] == top_id);
        eoi_miss = eoi_wr && !eoi_hit;
        mask_we  = reg_wr && (sel == SEL_MASK);
    end

    // Assemble the status word.
    always_comb begin
        stat_word                    = '0;
        stat_word[PRIO_W-1:0]        = running;
        stat_word[PRIO_W +: CNT_W]   = cnt;
        stat_word[DATA_W-1]          = err;
    end

    // Select read data for the addressed register.
    always_comb begin
        unique case (sel)
            SEL_MASK: reg_rdata = DATA_W'(mask);
            SEL_ACK:  reg_rdata = eligible ? DATA_W'(cand_id) : DATA_W'(SPUR_ID);
            SEL_EOI:  reg_rdata = '0;
            SEL_STAT: reg_rdata = stat_word;
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/cpu_irq_iface.sv
// Processor interrupt interface: masks the distributor's candidate against
// a priority mask and the running priority, raises the request line,
// serves acknowledge and end-of-service accesses, and reports both to the
// distributor as one-cycle pulses. Assumes one candidate per cycle.
module cpu_irq_iface
    import cpu_irq_pkg::*;
#(
    parameter int ID_W   = 10,
    parameter int PRIO_W = 8,
    parameter int DEPTH  = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cand_valid,
    input  logic [ID_W-1:0]   cand_id,
    input  logic [PRIO_W-1:0] cand_prio,
    input  logic              cand_act_pend,
    output logic              irq_req,
    output logic              ack_valid,
    output logic [ID_W-1:0]   ack_id,
    output logic              eoi_valid,
    output logic [ID_W-1:0]   eoi_id,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PRIO_W-1:0] IDLE_PRIO = '1;

    logic [PRIO_W-1:0] mask_q;
    logic              err_q;
    logic              irq_q;
    logic              ack_v_q, eoi_v_q;
    logic [ID_W-1:0]   ack_id_q, eoi_id_q;
    logic [ID_W-1:0]   top_id;
    logic [PRIO_W-1:0] top_prio, running;
    logic [CNT_W-1:0]  cnt;
    logic              empty, full, eligible;
    logic              ack_fire, eoi_hit, eoi_miss, mask_we;

    cpu_irq_stack #(
        .DEPTH(DEPTH), .ID_W(ID_W), .PRIO_W(PRIO_W), .CNT_W(CNT_W)
    ) u_stack (
        .clk(clk), .rst_n(rst_n),
        .push(ack_fire), .push_id(cand_id), .push_prio(cand_prio),
        .pop(eoi_hit),
        .top_id(top_id), .top_prio(top_prio), .cnt(cnt),
        .empty(empty), .full(full)
    );

    // Running priority: top of stack, idle value when nothing is in service.
    always_comb running = empty ? IDLE_PRIO : top_prio;

    cpu_irq_gate #(.PRIO_W(PRIO_W)) u_gate (
        .cand_valid(cand_valid), .cand_prio(cand_prio),
        .cand_act_pend(cand_act_pend), .mask(mask_q),
        .running(running), .full(full), .eligible(eligible)
    );

    cpu_irq_regs #(
        .ID_W(ID_W), .PRIO_W(PRIO_W), .CNT_W(CNT_W), .DATA_W(DATA_W)
    ) u_regs (
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .eligible(eligible), .cand_id(cand_id),
        .top_id(top_id), .empty(empty), .cnt(cnt), .running(running),
        .mask(mask_q), .err(err_q), .reg_rdata(reg_rdata),
        .ack_fire(ack_fire), .eoi_hit(eoi_hit), .eoi_miss(eoi_miss),
        .mask_we(mask_we)
    );

    // Mask register and sticky ordering error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            err_q  <= 1'b0;
        end else begin
            if (mask_we)  mask_q <= reg_wdata[PRIO_W-1:0];
            if (eoi_miss) err_q  <= 1'b1;
        end
    end

    // Request line: drop at once when the candidate is being acknowledged.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= eligible && !ack_fire;
    end

    // Notification pulses to the distributor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_v_q  <= 1'b0;
            eoi_v_q  <= 1'b0;
            ack_id_q <= '0;
            eoi_id_q <= '0;
        end else begin
            ack_v_q <= ack_fire;
            eoi_v_q <= eoi_hit;
            if (ack_fire) ack_id_q <= cand_id;
            if (eoi_hit)  eoi_id_q <= top_id;
        end
    end

    assign irq_req   = irq_q;
    assign ack_valid = ack_v_q;
    assign ack_id    = ack_id_q;
    assign eoi_valid = eoi_v_q;
    assign eoi_id    = eoi_id_q;
endmodule

// File: rtl/cpu_irq_iface_chk.sv
// Property checker for cpu_irq_iface, attached by bind.
module cpu_irq_iface_chk #(
    parameter int ID_W   = 10,
    parameter int PRIO_W = 8,
    parameter int DEPTH  = 8,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              irq_req,
    input logic              cand_valid,
    input logic [PRIO_W-1:0] cand_prio,
    input logic              cand_act_pend,
    input logic [PRIO_W-1:0] mask_q,
    input logic [PRIO_W-1:0] running,
    input logic              ack_valid,
    input logic              reg_rd,
    input logic [1:0]        reg_addr,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              eoi_valid,
    input logic [ID_W-1:0]   eoi_id,
    input logic [ID_W-1:0]   top_id,
    input logic [CNT_W-1:0]  cnt,
    input logic              err_q
);
    p_irq_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> $past(cand_valid && (cand_prio < mask_q)));

    p_irq_running_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> $past(cand_prio < running));

    p_no_actpend_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> !$past(cand_act_pend));

    p_ack_not_spurious_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |-> $past(reg_rd && (reg_addr == 2'd1)
                            && (reg_rdata[ID_W-1:0] != {ID_W{1'b1}})));

    p_eoi_top_r7: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_valid |-> ((eoi_id == $past(top_id)) && ($past(cnt) != '0)));

    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q);

    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(DEPTH));
endmodule

bind cpu_irq_iface cpu_irq_iface_chk #(
    .ID_W(ID_W), .PRIO_W(PRIO_W), .DEPTH(DEPTH), .DATA_W(DATA_W), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .cand_valid(cand_valid),
    .cand_prio(cand_prio), .cand_act_pend(cand_act_pend), .mask_q(mask_q),
    .running(running), .ack_valid(ack_valid), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_rdata(reg_rdata), .eoi_valid(eoi_valid),
    .eoi_id(eoi_id), .top_id(top_id), .cnt(cnt), .err_q(err_q)
);

// File: tb/tb_cpu_irq_iface.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks queue expected distributor notifications,
// a monitor pops and compares them as pulses appear.
module tb_cpu_irq_iface;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cand_valid = 1'b0;
    logic [9:0]  cand_id = '0;
    logic [7:0]  cand_prio = '0;
    logic        cand_act_pend = 1'b0;
    logic        irq_req, ack_valid, eoi_valid;
    logic [9:0]  ack_id, eoi_id;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;

    int checks = 0;
    int fails  = 0;

    typedef struct packed { logic is_eoi; logic [9:0] id; } note_t;
    note_t exp_q[$];

    always #2 clk = ~clk;

    cpu_irq_iface dut (
        .clk(clk), .rst_n(rst_n), .cand_valid(cand_valid), .cand_id(cand_id),
        .cand_prio(cand_prio), .cand_act_pend(cand_act_pend),
        .irq_req(irq_req), .ack_valid(ack_valid), .ack_id(ack_id),
        .eoi_valid(eoi_valid), .eoi_id(eoi_id), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic ack_read(input string req, input logic [9:0] exp_id);
        logic [31:0] d;
        reg_rd = 1'b1; reg_addr = 2'd1;
        #1 d = reg_rdata;
        chk(req, d, {22'd0, exp_id});
        if (exp_id != 10'h3FF) exp_q.push_back('{is_eoi: 1'b0, id: exp_id});
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic eoi_write(input logic [9:0] id, input logic hit);
        if (hit) exp_q.push_back('{is_eoi: 1'b1, id: id});
        reg_write(2'd2, {22'd0, id});
    endtask

    task automatic stat_chk(input string req, input logic [31:0] exp);
        logic [31:0] d;
        reg_read(2'd3, d);
        chk(req, d, exp);
    endtask

    task automatic offer(input logic v, input logic [9:0] id, input logic [7:0] p, input logic ap);
        cand_valid = v; cand_id = id; cand_prio = p; cand_act_pend = ap;
    endtask

    // Monitor: compare each notification pulse with the queued expectation.
    always @(negedge clk) begin
        if (rst_n && (ack_valid || eoi_valid)) begin
            if (ack_valid && eoi_valid) begin
                chk("R5 R7 both pulses", 32'd1, 32'd0);
            end else if (exp_q.size() == 0) begin
                chk(ack_valid ? "R6 unexpected ack" : "R8 unexpected eoi",
                    {22'd0, ack_valid ? ack_id : eoi_id}, 32'h0);
            end else begin
                note_t e;
                e = exp_q.pop_front();
                if (e.is_eoi) begin
                    chk("R7 eoi kind", {31'd0, eoi_valid}, 32'd1);
                    chk("R7 eoi id", {22'd0, eoi_id}, {22'd0, e.id});
                end else begin
                    chk("R5 ack kind", {31'd0, ack_valid}, 32'd1);
                    chk("R5 ack id", {22'd0, ack_id}, {22'd0, e.id});
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 irq", {31'd0, irq_req}, 32'd0);
        chk("R1 pulses", {30'd0, ack_valid, eoi_valid}, 32'd0);
        reg_read(2'd0, d); chk("R1 mask", d, 32'd0);
        stat_chk("R1 status", 32'h0000_00FF);

        // R10 mask write keeps the low byte
        reg_write(2'd0, 32'hFFFF_FF90);
        reg_read(2'd0, d); chk("R10 mask", d, 32'h90);
        reg_write(2'd0, 32'hA0);
        reg_read(2'd0, d); chk("R10 mask", d, 32'hA0);

        // R2 latency and withdrawal
        offer(1'b1, 10'd37, 8'h40, 1'b0);
        #1 chk("R2 not yet", {31'd0, irq_req}, 32'd0);
        @(negedge clk); chk("R2 raised", {31'd0, irq_req}, 32'd1);
        cand_valid = 1'b0;
        @(negedge clk); chk("R2 dropped", {31'd0, irq_req}, 32'd0);

        // R3 equal to mask, and less urgent than mask
        offer(1'b1, 10'd40, 8'hA0, 1'b0);
        @(negedge clk); chk("R3 equal mask", {31'd0, irq_req}, 32'd0);
        offer(1'b1, 10'd41, 8'hA1, 1'b0);
        @(negedge clk); chk("R3 above mask", {31'd0, irq_req}, 32'd0);

        // R4 active-and-pending is never signalled or acknowledged
        offer(1'b1, 10'd37, 8'h40, 1'b1);
        @(negedge clk); chk("R4 irq", {31'd0, irq_req}, 32'd0);
        ack_read("R4 ack spurious", 10'h3FF);

        // R5 acknowledge
        offer(1'b1, 10'd37, 8'h40, 1'b0);
        @(negedge clk); chk("R5 irq", {31'd0, irq_req}, 32'd1);
        ack_read("R5 ack id", 10'd37);
        chk("R5 irq low after ack", {31'd0, irq_req}, 32'd0);
        stat_chk("R5 status", 32'h0000_0140);

        // R3 equal to running priority, then nested preemption
        offer(1'b1, 10'd50, 8'h40, 1'b0);
        @(negedge clk); chk("R3 equal running", {31'd0, irq_req}, 32'd0);
        offer(1'b1, 10'd51, 8'h30, 1'b0);
        @(negedge clk); chk("R5 nested irq", {31'd0, irq_req}, 32'd1);
        ack_read("R5 nested ack", 10'd51);
        stat_chk("R5 nested status", 32'h0000_0230);
        cand_valid = 1'b0;

        // R8 wrong ID completion
        eoi_write(10'd37, 1'b0);
        stat_chk("R8 mismatch", 32'h8000_0230);

        // R7 completions in reverse order
        eoi_write(10'd51, 1'b1);
        stat_chk("R7 pop one", 32'h8000_0140);
        eoi_write(10'd37, 1'b1);
        stat_chk("R7 pop two", 32'h8000_00FF);

        // R6 spurious with no candidate; R8 completion on empty stack
        ack_read("R6 spurious", 10'h3FF);
        stat_chk("R6 status", 32'h8000_00FF);
        eoi_write(10'd37, 1'b0);
        stat_chk("R8 empty", 32'h8000_00FF);

        // R9 fill the stack
        for (int i = 0; i < 8; i++) begin
            offer(1'b1, 10'(100 + i), 8'(8'h90 - 8'(i * 16)), 1'b0);
            @(negedge clk); chk("R9 fill irq", {31'd0, irq_req}, 32'd1);
            ack_read("R9 fill ack", 10'(100 + i));
        end
        stat_chk("R9 full status", 32'h8000_0820);
        offer(1'b1, 10'd200, 8'h05, 1'b0);
        @(negedge clk); chk("R9 full blocks irq", {31'd0, irq_req}, 32'd0);
        ack_read("R9 full spurious", 10'h3FF);
        cand_valid = 1'b0;
        for (int i = 7; i >= 0; i--) eoi_write(10'(100 + i), 1'b1);
        stat_chk("R9 drained", 32'h8000_00FF);

        // R2 deassert when the mask is lowered
        offer(1'b1, 10'd60, 8'h40, 1'b0);
        @(negedge clk); chk("R2 irq before mask", {31'd0, irq_req}, 32'd1);
        reg_write(2'd0, 32'h30);
        chk("R2 one cycle later", {31'd0, irq_req}, 32'd1);
        @(negedge clk); chk("R2 masked", {31'd0, irq_req}, 32'd0);
        cand_valid = 1'b0;

        repeat (3) @(negedge clk);
        chk("R5 R7 queue drained", exp_q.size(), 32'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule